// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a parameterised synchronous up-counter with a preset port. All state bits are held in one register bank that is clocked on the rising edge, so every output bit changes at the same moment. A low level on the load input copies the preset data into the counter on the next edge. A low level on the clear input returns the counter to zero. A build-time parameter selects whether clear acts immediately (asynchronous) or at the next rising edge (synchronous). When neither clear nor load is active, the counter advances by one only if both count enables are high. Otherwise it holds its value.

The carry output is a decode of the all-ones state, gated by the chain enable only. It is therefore free of clock-edge glitches during counting. To chain stages, the carry of each stage drives the chain enable of the next stage, and all stages share the clock and the gate enable. This gives a wider counter without a carry that ripples through the clock. In synchronous-clear builds, an external decode of a chosen final count can drive the clear input. The count length then shortens to N states.

Top module: `psc_counter`

## Requirements
- R1: With clr_n and load_n high and both en_gate and en_chain high, q increases by one on the rising clock edge. The all-ones value wraps to zero.
- R2: With clr_n high and load_n low, q takes din on the next rising edge, whatever the levels of the two enables.
- R3: With ASYNC_CLR = 0, a low clr_n gives q equal to zero on the next rising edge, whatever load_n and the enables are. q does not change before that edge.
- R4: With ASYNC_CLR = 1, a low clr_n forces q to zero at once, with no clock edge. q stays zero while clr_n is low, whatever the load, enable or clock inputs do.
- R5: With clr_n and load_n high and either enable low, q keeps its value across the clock edge.
- R6: co is 1 exactly when q is all ones and en_chain is 1. co does not depend on en_gate or on the clock.
- R7: When two stages share the clock, clear, load and en_gate, and the low stage's co drives the high stage's en_chain, the two stages count as one counter of twice the width. The high stage is the upper half.
- R8: In a synchronous-clear build, driving clr_n low from a decode of the combined count N-1 makes the counter step through 0 to N-1 and then return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous preset |
| din | input | W | Preset data |
| en_gate | input | 1 | Count enable shared by all chained stages |
| en_chain | input | 1 | Count enable that also gates co; fed by the previous stage's co |
| q | output | W | Counter value |
| co | output | 1 | Terminal-count carry: q all ones and en_chain high |

## Verification
The clocked checks assume that clr_n acts as the only reset and that it starts low. In an asynchronous build they also assume that clr_n never changes exactly at a rising edge, so a clear is either fully in effect or fully released when the edge samples q. The stimulus follows these assumptions. It holds clear low from time zero through the first edges. It changes every input one nanosecond after the falling edge. In the asynchronous build it asserts clear only in the middle of a cycle. Random runs use high clear and load densities so that the priority order is exercised often.

// File: rtl/psc_pkg.sv
package psc_pkg;

    // Operation selected for the next clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } psc_op_e;

endpackage

// File: rtl/psc_op_dec.sv
module psc_op_dec
    import psc_pkg::*;
(
    input  logic    clr_req,
    input  logic    load_n,
    input  logic    en_gate,
    input  logic    en_chain,
    output psc_op_e op
);

    // Clear beats load, load beats count, count beats hold.
    always_comb begin
        if (clr_req) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_gate && en_chain) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/psc_incr.sv
module psc_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cnt_inc,
    output logic         at_top
);

    // Each toggle term is a flat AND of all lower bits (lookahead),
    // so no bit waits on a carry chain through its neighbours.
    logic [W-1:0] tog;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign tog[i] = 1'b1;
            end else begin : g_up
                assign tog[i] = &cnt[i-1:0];
            end
            assign cnt_inc[i] = cnt[i] ^ tog[i];
        end
    endgenerate

    assign at_top = &cnt;

endmodule

// File: rtl/psc_carry.sv
module psc_carry (
    input  logic at_top,
    input  logic en_chain,
    output logic co
);

    // Decoded from registered state only, so counting causes no hazard.
    assign co = at_top & en_chain;

endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int W         = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_gate,
    input  logic         en_chain,
    output logic [W-1:0] q,
    output logic         co
);
    import psc_pkg::*;

    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    psc_op_e      op;
    logic [W-1:0] cnt_inc;
    logic         at_top;
    logic         clr_req;

    // In the asynchronous build the register itself handles clear.
    assign clr_req = ASYNC_CLR ? 1'b0 : ~clr_n;

    psc_op_dec u_dec (
        .clr_req  (clr_req),
        .load_n   (load_n),
        .en_gate  (en_gate),
        .en_chain (en_chain),
        .op       (op)
    );

    psc_incr #(.W(W)) u_inc (
        .cnt     (st_q.cnt),
        .cnt_inc (cnt_inc),
        .at_top  (at_top)
    );

    psc_carry u_cy (
        .at_top   (at_top),
        .en_chain (en_chain),
        .co       (co)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = ZERO;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = cnt_inc;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q = st_q.cnt;

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int W         = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_gate,
    input logic         en_chain,
    input logic [W-1:0] q,
    input logic         co
);

    // R1: enabled count step
    p_count_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_gate && en_chain) |=> (q == $past(q) + W'(1)));

    // R2: load takes the preset data
    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (q == $past(din)));

    // R5: a missing enable holds the value
    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_gate && en_chain)) |=> $stable(q));

    // R6: carry needs the chain enable
    p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
        co |-> en_chain);

    // R6: carry only at the top value
    p_carry_top_r6: assert property (@(posedge clk) disable iff (!clr_n)
        co |-> (&q));

    // R1 with R6: a counting edge taken while the carry is high wraps to zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (co && en_gate && load_n) |=> (q == '0));

    generate
        if (ASYNC_CLR) begin : g_async_chk
            // R4: the clear has already taken effect when an edge samples q
            p_async_clr_r4: assert property (@(posedge clk)
                (!clr_n) |-> (q == '0));
        end else begin : g_sync_chk
            // R3: clear gives zero after the edge
            p_sync_clr_r3: assert property (@(posedge clk)
                (!clr_n) |=> (q == '0));
        end
    endgenerate

endmodule

bind psc_counter psc_checker #(.W(W), .ASYNC_CLR(ASYNC_CLR)) chk_i (.*);

// File: tb/psc_counter_tb_top.sv
`timescale 1ns/1ps
module psc_counter_tb_top;

    localparam int W  = 4;
    localparam int MN = 37;
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    // Cascaded synchronous-clear pair
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic [2*W-1:0] din = '0;
    logic         en_gate = 1'b0;
    logic         en_chain0 = 1'b0;
    logic [W-1:0] q_lo, q_hi;
    logic         co_lo, co_hi;

    // Standalone asynchronous-clear stage
    logic         a_clr_n = 1'b0;
    logic         a_load_n = 1'b1;
    logic [W-1:0] a_din = '0;
    logic         a_eg = 1'b0;
    logic         a_ec = 1'b0;
    logic [W-1:0] a_q;
    logic         a_co;

    psc_counter #(.W(W), .ASYNC_CLR(1'b0)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[W-1:0]),
        .en_gate(en_gate), .en_chain(en_chain0), .q(q_lo), .co(co_lo));

    psc_counter #(.W(W), .ASYNC_CLR(1'b0)) hi_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[2*W-1:W]),
        .en_gate(en_gate), .en_chain(co_lo), .q(q_hi), .co(co_hi));

    psc_counter #(.W(W), .ASYNC_CLR(1'b1)) async_i (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .din(a_din),
        .en_gate(a_eg), .en_chain(a_ec), .q(a_q), .co(a_co));

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [W-1:0] m_lo = '0, m_hi = '0, m_a = '0;

    function automatic logic [W-1:0] f_next(input logic [W-1:0] cur, input logic clr,
            input logic ld, input logic [W-1:0] d, input logic eg, input logic ec);
        if (!clr)          return '0;
        else if (!ld)      return d;
        else if (eg && ec) return cur + W'(1);
        else               return cur;
    endfunction

    function automatic logic f_co(input logic [W-1:0] cur, input logic ec);
        return (cur == TOP) && ec;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic cas_step(input logic c, input logic l, input logic [2*W-1:0] d,
                            input logic eg, input logic ec);
        logic lo_cy;
        clr_n = c; load_n = l; din = d; en_gate = eg; en_chain0 = ec;
        #1;
        lo_cy = f_co(m_lo, ec);
        check("R6 lo carry", int'(co_lo), int'(lo_cy));
        check("R7 hi carry", int'(co_hi), int'(f_co(m_hi, lo_cy)));
        m_hi = f_next(m_hi, c, l, d[2*W-1:W], eg, lo_cy);
        m_lo = f_next(m_lo, c, l, d[W-1:0], eg, ec);
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R1/R2/R3/R5 lo", int'(q_lo), int'(m_lo));
        check("R7 hi", int'(q_hi), int'(m_hi));
    endtask

    task automatic a_step(input logic l, input logic [W-1:0] d, input logic eg,
                          input logic ec, input logic pulse);
        a_clr_n = 1'b1; a_load_n = l; a_din = d; a_eg = eg; a_ec = ec;
        #1;
        check("R6 async carry", int'(a_co), int'(f_co(m_a, ec)));
        if (pulse) begin
            #1 a_clr_n = 1'b0;
            #1;
            m_a = '0;
            check("R4 immediate clear", int'(a_q), 0);
        end else begin
            m_a = f_next(m_a, 1'b1, l, d, eg, ec);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R4/R1/R2/R5 async q", int'(a_q), int'(m_a));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seq;
        void'($urandom(32'd4242));
        // Reset state: async stage clears with no clock edge
        #1;
        check("R4 reset without clock", int'(a_q), 0);
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1;
        check("R3 reset lo", int'(q_lo), 0);
        check("R3 reset hi", int'(q_hi), 0);
        m_lo = '0; m_hi = '0; m_a = '0;

        // R2: load with both enables low
        cas_step(1'b1, 1'b0, 8'hA5, 1'b0, 1'b0);
        check("R2 load ignores enables", int'({q_hi, q_lo}), 8'hA5);
        // R5: hold with either enable low
        cas_step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
        check("R5 hold en_gate low", int'({q_hi, q_lo}), 8'hA5);
        cas_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R5 hold en_chain low", int'({q_hi, q_lo}), 8'hA5);
        // R1/R7: nibble carry into the upper stage
        cas_step(1'b1, 1'b0, 8'h2F, 1'b1, 1'b1);
        cas_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        check("R7 nibble carry", int'({q_hi, q_lo}), 8'h30);
        // R1: full wrap of the pair
        cas_step(1'b1, 1'b0, 8'hFF, 1'b1, 1'b1);
        en_gate = 1'b0; en_chain0 = 1'b1; #1;
        check("R6 carry with en_gate low", int'(co_lo), 1);
        en_chain0 = 1'b0; #1;
        check("R6 carry needs en_chain", int'(co_lo), 0);
        cas_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        check("R1 wrap to zero", int'({q_hi, q_lo}), 0);
        // R3: sync clear waits for the edge and beats load
        cas_step(1'b1, 1'b0, 8'h5C, 1'b0, 1'b0);
        clr_n = 1'b0; load_n = 1'b0; din = 8'h11; #2;
        check("R3 no change before edge", int'({q_hi, q_lo}), 8'h5C);
        cas_step(1'b0, 1'b0, 8'h11, 1'b1, 1'b1);
        check("R3 clear beats load", int'({q_hi, q_lo}), 0);

        // Random mix on the cascade
        for (int i = 0; i < 600; i++) begin
            cas_step(($urandom % 16) != 0, ($urandom % 8) != 0, 8'($urandom),
                     ($urandom % 4) != 0, ($urandom % 4) != 0);
        end

        // R8: modulo-MN truncation through the clear input
        cas_step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
        seq = 0;
        for (int i = 0; i < 3 * MN; i++) begin
            cas_step(({m_hi, m_lo} != 8'(MN - 1)), 1'b1, 8'h00, 1'b1, 1'b1);
            seq = (seq == MN - 1) ? 0 : seq + 1;
            check("R8 modulo sequence", int'({q_hi, q_lo}), seq);
        end

        // Asynchronous stage: directed then random
        a_step(1'b0, 4'd9, 1'b0, 1'b0, 1'b0);
        check("R2 async load", int'(a_q), 9);
        a_step(1'b0, 4'd6, 1'b1, 1'b1, 1'b1);
        check("R4 clear beats load", int'(a_q), 0);
        a_step(1'b0, 4'hF, 1'b0, 1'b0, 1'b0);
        a_step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0);
        check("R1 async wrap", int'(a_q), 0);
        for (int i = 0; i < 400; i++) begin
            a_step(($urandom % 6) != 0, 4'($urandom), ($urandom % 4) != 0,
                   ($urandom % 4) != 0, ($urandom % 8) == 0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule